// File: doc/BRIEF.md
# Swizzled Vector Instruction Execute Unit

This block carries out one register-format shader instruction per clock on vectors of four signed fixed-point components. The 32-bit instruction word names an opcode, a destination register, two source registers and an operand descriptor. The descriptor is a 32-bit word taken from a small table that the host fills beforehand. It supplies a component selector for each source and a destination write mask, so the same instruction can reorder or replicate components and update only part of a register.

Register IDs are six bits wide. Their meaning depends on the direction of the access. As a source, the low sixteen IDs read externally fed attribute vectors. As a destination, the same IDs write output registers, which the host reads through a separate port. The upper thirty-two IDs name uniform registers in both directions. The supported operations are a three-component dot product, a four-component dot product and a move. A dot product's scalar result is written to every component that the mask enables.

Top module: `vxu_top`

## Requirements
- R1: After a synchronous active-low reset, every output register reads zero, the descriptor table and uniform registers are cleared, and `done_o` and `illegal_o` are low.
- R2: Instruction fields sit at fixed positions: opcode in bits 31:26, destination ID in 25:20, first source in 17:12, second source in 11:6 and descriptor ID in 5:0. Instruction bits 19:18 and descriptor bit 31 are carried but have no effect on the result.
- R3: A selector byte picks a source component for each result component. Bits 7:6 pick result x, 5:4 pick y, 3:2 pick z and 1:0 pick w, where code 0 means x, 1 means y, 2 means z and 3 means w. Descriptor bits 12:5 hold the first-source selector and bits 27:20 hold the second-source selector.
- R4: Opcode 0x13 copies the swizzled first source to the destination.
- R5: Opcode 0x02 sums the four signed 16x16 products of the swizzled sources at full width and keeps the low 16 bits.
- R6: Opcode 0x01 does the same as R5 over the x, y and z products only.
- R7: Descriptor bits 3:0 form the write mask: bit 3 enables x, bit 2 y, bit 1 z and bit 0 w. A disabled component keeps its old value. A dot-product result goes to every enabled component.
- R8: Source IDs 0x00–0x0F read attribute vectors and destination IDs 0x00–0x0F write output registers. IDs 0x20–0x3F read and write uniform registers 0–31 in both directions.
- R9: Any ID in 0x10–0x1F is unmapped. A read from one returns zero and a write to one is dropped. When an instruction touches an unmapped ID, `illegal_o` is high for the one cycle after the instruction.
- R10: An opcode other than 0x01, 0x02 or 0x13 writes nothing and does not raise `illegal_o`.
- R11: `done_o` is high in exactly the cycle after each cycle in which `instr_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_we | input | 1 | Descriptor table write strobe |
| desc_addr | input | 6 | Descriptor table word index |
| desc_wdata | input | 32 | Descriptor word to store |
| uni_we | input | 1 | Host uniform register write strobe |
| uni_addr | input | 5 | Host uniform register index |
| uni_wdata | input | 64 | Host uniform vector; x in bits 15:0, w in bits 63:48 |
| attr_data | input | 1024 | Sixteen attribute vectors; vector k at bits 64k+63:64k |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| out_addr | input | 4 | Output register read index |
| out_rdata | output | 64 | Contents of the selected output register |
| done_o | output | 1 | Pulses one cycle after each instruction |
| illegal_o | output | 1 | Pulses one cycle after an instruction that touched an unmapped ID |

## Verification
The hardest cases to reach are the ones where an instruction must leave a register exactly as it was: a zero write mask, an unmapped destination, and an unknown opcode. A register that already holds zero cannot show whether a write was blocked. So the stimulus first fills the target output register with a distinctive value, then issues the instruction that must not touch it, and then reads the register back. An unmapped destination is aimed at an ID whose low four bits equal an output register that already holds data, so a decode that wrongly folded the ID onto the output bank would show up at the read port.

// File: rtl/vxu_pkg.sv
// Package vxu_pkg
// Shared field widths, opcode values and the bank type for the vector
// execute unit. The widths are fixed by the instruction and descriptor format.
package vxu_pkg;

    localparam int ID_W    = 6;
    localparam int OP_W    = 6;
    localparam int SEL_W   = 8;
    localparam int MASK_W  = 4;
    localparam int NCOMP   = 4;
    localparam int INSTR_W = 32;
    localparam int DESC_W  = 32;

    localparam logic [OP_W-1:0] OP_DP3 = 6'h01;
    localparam logic [OP_W-1:0] OP_DP4 = 6'h02;
    localparam logic [OP_W-1:0] OP_MOV = 6'h13;

    typedef enum logic [1:0] {
        BANK_NONE = 2'd0,
        BANK_ATTR = 2'd1,
        BANK_OUT  = 2'd2,
        BANK_UNI  = 2'd3
    } bank_e;

endpackage

// File: rtl/vxu_decode.sv
// Module vxu_decode
// Splits the instruction word and the descriptor word into fields, and maps
// each register ID to a bank. The mapping depends on whether the ID is read
// or written. Purely combinational.
// Assumes: 6-bit IDs; 0x20-0x3F uniform, 0x10-0x1F unmapped.
module vxu_decode
    import vxu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DESC_W-1:0]  desc_word_i,
    output logic [ID_W-1:0]    desc_id_o,
    output bank_e              src1_bank_o,
    output bank_e              src2_bank_o,
    output bank_e              dst_bank_o,
    output logic [4:0]         src1_idx_o,
    output logic [4:0]         src2_idx_o,
    output logic [4:0]         dst_idx_o,
    output logic [MASK_W-1:0]  mask_o,
    output logic [SEL_W-1:0]   sel1_o,
    output logic [SEL_W-1:0]   sel2_o,
    output logic               is_mov_o,
    output logic               is_dp3_o,
    output logic               is_dp4_o
);

    logic [OP_W-1:0] op;
    logic [ID_W-1:0] dst_id, s1_id, s2_id;

    // Map an ID used as a source to its bank
    function automatic bank_e map_src(input logic [ID_W-1:0] id);
        if (id[5])      return BANK_UNI;
        else if (id[4]) return BANK_NONE;
        else            return BANK_ATTR;
    endfunction

    // Map an ID used as a destination to its bank
    function automatic bank_e map_dst(input logic [ID_W-1:0] id);
        if (id[5])      return BANK_UNI;
        else if (id[4]) return BANK_NONE;
        else            return BANK_OUT;
    endfunction

    // Extract instruction fields; bits 19:18 are flags and are not used
    always_comb begin
        op        = instr_i[31:26];
        dst_id    = instr_i[25:20];
        s1_id     = instr_i[17:12];
        s2_id     = instr_i[11:6];
        desc_id_o = instr_i[5:0];
    end

    // Bank and index lookup for each operand
    always_comb begin
        src1_bank_o = map_src(s1_id);
        src2_bank_o = map_src(s2_id);
        dst_bank_o  = map_dst(dst_id);
        src1_idx_o  = s1_id[4:0];
        src2_idx_o  = s2_id[4:0];
        dst_idx_o   = dst_id[4:0];
    end

    // Descriptor fields; bit 31 is a flag and is not used
    always_comb begin
        mask_o = desc_word_i[3:0];
        sel1_o = desc_word_i[12:5];
        sel2_o = desc_word_i[27:20];
    end

    // Opcode classification
    always_comb begin
        is_mov_o = (op == OP_MOV);
        is_dp3_o = (op == OP_DP3);
        is_dp4_o = (op == OP_DP4);
    end

endmodule

// File: rtl/vxu_swizzle.sv
// Module vxu_swizzle
// Rearranges the components of one vector under an 8-bit selector.
// Result component c (0 = x) takes the source component named by selector
// bits [7-2c : 6-2c]. Component c is stored at bits [c*COMP_W +: COMP_W].
module vxu_swizzle
    import vxu_pkg::*;
#(
    parameter int COMP_W = 16
) (
    input  logic [NCOMP*COMP_W-1:0] vec_i,
    input  logic [SEL_W-1:0]        sel_i,
    output logic [NCOMP*COMP_W-1:0] vec_o
);

    logic [COMP_W-1:0] comp [NCOMP];

    // Unpack the source components
    always_comb begin
        for (int k = 0; k < NCOMP; k++) comp[k] = vec_i[k*COMP_W +: COMP_W];
    end

    for (genvar c = 0; c < NCOMP; c++) begin : g_lane
        localparam int HI = SEL_W - 1 - 2*c;
        // Route the selected source component to lane c
        always_comb vec_o[c*COMP_W +: COMP_W] = comp[sel_i[HI -: 2]];
    end

endmodule

// File: rtl/vxu_dot.sv
// Module vxu_dot
// Signed dot product of two four-component vectors. The w product is added
// only when use_w_i is set. The sum is formed at full width and then cut
// down to COMP_W bits.
module vxu_dot
    import vxu_pkg::*;
#(
    parameter int COMP_W = 16
) (
    input  logic [NCOMP*COMP_W-1:0] a_i,
    input  logic [NCOMP*COMP_W-1:0] b_i,
    input  logic                    use_w_i,
    output logic [COMP_W-1:0]       dot_o
);

    localparam int PROD_W = 2 * COMP_W;
    localparam int SUM_W  = PROD_W + 2;

    logic signed [PROD_W-1:0] prod [NCOMP];
    logic signed [SUM_W-1:0]  sum;

    // Per-lane signed products
    for (genvar c = 0; c < NCOMP; c++) begin : g_mul
        always_comb prod[c] = $signed(a_i[c*COMP_W +: COMP_W]) *
                              $signed(b_i[c*COMP_W +: COMP_W]);
    end

    // Accumulate at full width; the w lane is gated for the 3-wide form
    always_comb begin
        sum = '0;
        for (int k = 0; k < NCOMP; k++) begin
            if (k < NCOMP - 1 || use_w_i) sum = sum + SUM_W'(prod[k]);
        end
        dot_o = sum[COMP_W-1:0];
    end

endmodule

// File: rtl/vxu_top.sv
// Module vxu_top
// Executes one register-format instruction per cycle. The descriptor lookup,
// operand read, swizzle, dot product and masked merge all happen in one
// cycle, and the result is written at the clock edge. done_o and illegal_o
// are registered and report the instruction of the previous cycle.
// Assumes: NUM_OUT <= 16, NUM_ATTR <= 16, NUM_UNI == 32 (set by the ID map).
// If a host uniform write and an instruction write hit the same uniform
// register in one cycle, the instruction write wins.
module vxu_top
    import vxu_pkg::*;
#(
    parameter int COMP_W   = 16,
    parameter int NUM_ATTR = 16,
    parameter int NUM_OUT  = 16,
    parameter int NUM_UNI  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            desc_we,
    input  logic [ID_W-1:0]                 desc_addr,
    input  logic [DESC_W-1:0]               desc_wdata,
    input  logic                            uni_we,
    input  logic [$clog2(NUM_UNI)-1:0]      uni_addr,
    input  logic [NCOMP*COMP_W-1:0]         uni_wdata,
    input  logic [NUM_ATTR*NCOMP*COMP_W-1:0] attr_data,
    input  logic                            instr_valid,
    input  logic [INSTR_W-1:0]              instr,
    input  logic [$clog2(NUM_OUT)-1:0]      out_addr,
    output logic [NCOMP*COMP_W-1:0]         out_rdata,
    output logic                            done_o,
    output logic                            illegal_o
);

    localparam int VEC_W      = NCOMP * COMP_W;
    localparam int DESC_DEPTH = 2 ** ID_W;
    localparam int OUT_AW     = $clog2(NUM_OUT);
    localparam int ATTR_AW    = $clog2(NUM_ATTR);

    logic [DESC_DEPTH-1:0][DESC_W-1:0] desc_q;
    logic [NUM_UNI-1:0][VEC_W-1:0]     uni_q;
    logic [NUM_OUT-1:0][VEC_W-1:0]     out_q;
    logic                              done_q, illegal_q;

    logic [ID_W-1:0]   desc_id;
    bank_e             src1_bank, src2_bank, dst_bank;
    logic [4:0]        src1_idx, src2_idx, dst_idx;
    logic [MASK_W-1:0] wmask;
    logic [SEL_W-1:0]  sel1, sel2;
    logic              is_mov, is_dp3, is_dp4, known_op;
    logic [VEC_W-1:0]  src1_v, src2_v, swz1_v, swz2_v, res_v, old_v, merged_v;
    logic [COMP_W-1:0] dot_s;
    logic              do_write, touch_unmapped;

    vxu_decode u_decode (
        .instr_i     (instr),
        .desc_word_i (desc_q[desc_id]),
        .desc_id_o   (desc_id),
        .src1_bank_o (src1_bank),
        .src2_bank_o (src2_bank),
        .dst_bank_o  (dst_bank),
        .src1_idx_o  (src1_idx),
        .src2_idx_o  (src2_idx),
        .dst_idx_o   (dst_idx),
        .mask_o      (wmask),
        .sel1_o      (sel1),
        .sel2_o      (sel2),
        .is_mov_o    (is_mov),
        .is_dp3_o    (is_dp3),
        .is_dp4_o    (is_dp4)
    );

    // Fetch a source vector from its bank; unmapped IDs read as zero
    function automatic logic [VEC_W-1:0] read_src(input bank_e b, input logic [4:0] idx);
        logic [VEC_W-1:0] v;
        v = '0;
        case (b)
            BANK_ATTR: if (int'(idx) < NUM_ATTR)
                           v = attr_data[int'(idx[ATTR_AW-1:0])*VEC_W +: VEC_W];
            BANK_UNI:  v = uni_q[idx];
            default:   v = '0;
        endcase
        return v;
    endfunction

    // Operand read from the source banks
    always_comb begin
        src1_v = read_src(src1_bank, src1_idx);
        src2_v = read_src(src2_bank, src2_idx);
    end

    vxu_swizzle #(.COMP_W(COMP_W)) u_swz1 (.vec_i(src1_v), .sel_i(sel1), .vec_o(swz1_v));
    vxu_swizzle #(.COMP_W(COMP_W)) u_swz2 (.vec_i(src2_v), .sel_i(sel2), .vec_o(swz2_v));

    vxu_dot #(.COMP_W(COMP_W)) u_dot (
        .a_i     (swz1_v),
        .b_i     (swz2_v),
        .use_w_i (is_dp4),
        .dot_o   (dot_s)
    );

    // Pick the result vector and the current contents of the destination
    always_comb begin
        known_op = is_mov | is_dp3 | is_dp4;
        res_v    = is_mov ? swz1_v : {NCOMP{dot_s}};
        old_v    = (dst_bank == BANK_UNI) ? uni_q[dst_idx] : out_q[dst_idx[OUT_AW-1:0]];
    end

    // Per-component merge; mask bit 3 guards x and bit 0 guards w
    for (genvar c = 0; c < NCOMP; c++) begin : g_merge
        always_comb merged_v[c*COMP_W +: COMP_W] =
            wmask[NCOMP-1-c] ? res_v[c*COMP_W +: COMP_W] : old_v[c*COMP_W +: COMP_W];
    end

    // Write qualification and unmapped-ID detection
    always_comb begin
        do_write       = instr_valid && known_op && (dst_bank != BANK_NONE);
        touch_unmapped = (src1_bank == BANK_NONE) || (dst_bank == BANK_NONE) ||
                         (!is_mov && (src2_bank == BANK_NONE));
    end

    // Storage update: host ports first, instruction writeback last so it wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
            uni_q  <= '0;
            out_q  <= '0;
        end else begin
            if (desc_we) desc_q[desc_addr] <= desc_wdata;
            if (uni_we)  uni_q[uni_addr]   <= uni_wdata;
            if (do_write && dst_bank == BANK_UNI) uni_q[dst_idx] <= merged_v;
            if (do_write && dst_bank == BANK_OUT) out_q[dst_idx[OUT_AW-1:0]] <= merged_v;
        end
    end

    // Completion and illegal-access pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= instr_valid;
            illegal_q <= instr_valid && known_op && touch_unmapped;
        end
    end

    // Output register read port
    always_comb begin
        out_rdata = out_q[out_addr];
        done_o    = done_q;
        illegal_o = illegal_q;
    end

    AST_DONE_AFTER_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> done_o); // R11
    AST_NO_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !done_o); // R11
    AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> done_o); // R9
    AST_UNMAPPED_DST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && dst_bank == BANK_NONE && !uni_we) |=> ($stable(out_q) && $stable(uni_q))); // R9
    AST_ZERO_MASK_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && wmask == '0 && !uni_we) |=> ($stable(out_q) && $stable(uni_q))); // R7
    AST_UNKNOWN_OP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !known_op && !uni_we) |=> ($stable(out_q) && $stable(uni_q) && !illegal_o)); // R10

endmodule

// File: tb/tb_vxu_top.sv
`timescale 1ns/1ps
module tb_vxu_top;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          desc_we = 1'b0;
    logic [5:0]    desc_addr = '0;
    logic [31:0]   desc_wdata = '0;
    logic          uni_we = 1'b0;
    logic [4:0]    uni_addr = '0;
    logic [63:0]   uni_wdata = '0;
    logic [1023:0] attr_data = '0;
    logic          instr_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic [3:0]    out_addr = '0;
    logic [63:0]   out_rdata;
    logic          done_o, illegal_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        int          kind;   // 0: output register read, 1: pulse check
        logic [3:0]  addr;
        logic [63:0] val;
        logic        done_e;
        logic        ill_e;
        string       tag;
    } item_t;
    item_t sb_q[$];

    vxu_top dut (
        .clk(clk), .rst_n(rst_n),
        .desc_we(desc_we), .desc_addr(desc_addr), .desc_wdata(desc_wdata),
        .uni_we(uni_we), .uni_addr(uni_addr), .uni_wdata(uni_wdata),
        .attr_data(attr_data),
        .instr_valid(instr_valid), .instr(instr),
        .out_addr(out_addr), .out_rdata(out_rdata),
        .done_o(done_o), .illegal_o(illegal_o)
    );

    always #10 clk = ~clk;

    localparam logic [5:0] DP3 = 6'h01, DP4 = 6'h02, MOV = 6'h13;

    function automatic logic [63:0] vec(input logic [15:0] x, input logic [15:0] y,
                                        input logic [15:0] z, input logic [15:0] w);
        return {w, z, y, x};
    endfunction

    function automatic logic [31:0] mk_desc(input logic [3:0] m, input logic [7:0] s1,
                                            input logic [7:0] s2, input logic fl);
        return {fl, 3'b000, s2, 7'b0, s1, 1'b0, m};
    endfunction

    task automatic put_desc(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); desc_we = 1'b1; desc_addr = a; desc_wdata = d;
        @(negedge clk); desc_we = 1'b0;
    endtask

    task automatic put_uni(input logic [4:0] a, input logic [63:0] v);
        @(negedge clk); uni_we = 1'b1; uni_addr = a; uni_wdata = v;
        @(negedge clk); uni_we = 1'b0;
    endtask

    // Driver: issue one instruction and queue the pulse expectation
    task automatic run(input logic [5:0] op, input logic [5:0] dst, input logic [5:0] s1,
                       input logic [5:0] s2, input logic [5:0] d, input logic [1:0] fl,
                       input logic ill_e, input string tag);
        item_t it;
        @(negedge clk);
        instr = {op, dst, fl, s1, s2, d};
        instr_valid = 1'b1;
        it.kind = 1; it.addr = '0; it.val = '0; it.done_e = 1'b1; it.ill_e = ill_e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    // Driver: queue an output register expectation, give the monitor a cycle
    task automatic expect_out(input logic [3:0] a, input logic [63:0] v, input string tag);
        item_t it;
        it.kind = 0; it.addr = a; it.val = v; it.done_e = 1'b0; it.ill_e = 1'b0; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic expect_idle(input string tag);
        item_t it;
        it.kind = 1; it.addr = '0; it.val = '0; it.done_e = 1'b0; it.ill_e = 1'b0; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: pop expectations and compare away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                if (it.kind == 0) begin
                    out_addr = it.addr;
                    #1;
                    checks++;
                    if (out_rdata !== it.val) begin
                        errors++;
                        $display("FAIL %s out[%0d] actual %h expected %h", it.tag, it.addr, out_rdata, it.val);
                    end
                end else begin
                    checks++;
                    if (done_o !== it.done_e || illegal_o !== it.ill_e) begin
                        errors++;
                        $display("FAIL %s done/illegal actual %b%b expected %b%b",
                                 it.tag, done_o, illegal_o, it.done_e, it.ill_e);
                    end
                end
            end
        end
    end

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            summary();
        end
    end

    initial begin
        attr_data[0*64 +: 64] = vec(16'd10, 16'd20, 16'd30, 16'd40);
        attr_data[1*64 +: 64] = vec(16'hFFFF, 16'hFFFE, 16'hFFFD, 16'hFFFC);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_idle("R1");
        for (int k = 0; k < 3; k++) expect_out(4'(k), 64'd0, "R1");

        put_desc(6'd0, mk_desc(4'hF, 8'h1B, 8'h1B, 1'b0));
        put_desc(6'd1, mk_desc(4'h8, 8'h1B, 8'h1B, 1'b0));
        put_desc(6'd2, mk_desc(4'hF, 8'h55, 8'h1B, 1'b0));
        put_desc(6'd3, mk_desc(4'h5, 8'hE4, 8'h1B, 1'b0));
        put_desc(6'd4, mk_desc(4'h0, 8'h1B, 8'h1B, 1'b0));
        put_desc(6'd5, mk_desc(4'hF, 8'h1B, 8'h1B, 1'b1));
        put_desc(6'd6, mk_desc(4'hF, 8'h1B, 8'h00, 1'b0));
        put_uni(5'd0, vec(16'd1, 16'd2, 16'd3, 16'd4));
        put_uni(5'd1, vec(16'd5, 16'd6, 16'd7, 16'd8));
        put_uni(5'd2, vec(16'hFFFD, 16'd1000, 16'd300, 16'hFFFE));

        // R4: plain move from uniform 0 to output 0
        run(MOV, 6'h00, 6'h20, 6'h00, 6'd0, 2'b00, 1'b0, "R4");
        expect_out(4'd0, vec(16'd1, 16'd2, 16'd3, 16'd4), "R4");
        // R3: replicate y
        run(MOV, 6'h01, 6'h20, 6'h00, 6'd2, 2'b00, 1'b0, "R3");
        expect_out(4'd1, vec(16'd2, 16'd2, 16'd2, 16'd2), "R3");
        // R3 reversal with R7 mask y,w
        run(MOV, 6'h02, 6'h20, 6'h00, 6'd3, 2'b00, 1'b0, "R7");
        expect_out(4'd2, vec(16'd0, 16'd3, 16'd0, 16'd1), "R7");
        // R5: full four-lane dot product, broadcast
        run(DP4, 6'h03, 6'h20, 6'h21, 6'd0, 2'b00, 1'b0, "R5");
        expect_out(4'd3, vec(16'd70, 16'd70, 16'd70, 16'd70), "R5");
        // R6: three-lane dot product, x only
        run(DP3, 6'h04, 6'h20, 6'h21, 6'd1, 2'b00, 1'b0, "R6");
        expect_out(4'd4, vec(16'd38, 16'd0, 16'd0, 16'd0), "R6");
        // R8: attribute sources, negative result
        run(DP4, 6'h05, 6'h00, 6'h01, 6'd0, 2'b00, 1'b0, "R8");
        expect_out(4'd5, vec(16'hFED4, 16'hFED4, 16'hFED4, 16'hFED4), "R8");
        // R5: truncation of a wide sum
        run(DP4, 6'h06, 6'h22, 6'h22, 6'd0, 2'b00, 1'b0, "R5");
        expect_out(4'd6, vec(16'hA1DD, 16'hA1DD, 16'hA1DD, 16'hA1DD), "R5");
        // R9: unmapped source reads zero and flags
        run(MOV, 6'h07, 6'h21, 6'h00, 6'd0, 2'b00, 1'b0, "R9");
        run(MOV, 6'h07, 6'h10, 6'h00, 6'd0, 2'b00, 1'b1, "R9");
        expect_out(4'd7, 64'd0, "R9");
        // R9: unmapped destination dropped; low bits alias output 5
        run(MOV, 6'h15, 6'h20, 6'h00, 6'd0, 2'b00, 1'b1, "R9");
        expect_out(4'd5, vec(16'hFED4, 16'hFED4, 16'hFED4, 16'hFED4), "R9");
        // R7: zero mask leaves output 0 alone
        run(MOV, 6'h00, 6'h21, 6'h00, 6'd4, 2'b00, 1'b0, "R7");
        expect_out(4'd0, vec(16'd1, 16'd2, 16'd3, 16'd4), "R7");
        // R8: uniform as destination, then read back through an output
        run(MOV, 6'h23, 6'h00, 6'h00, 6'd0, 2'b00, 1'b0, "R8");
        run(MOV, 6'h08, 6'h23, 6'h00, 6'd0, 2'b00, 1'b0, "R8");
        expect_out(4'd8, vec(16'd10, 16'd20, 16'd30, 16'd40), "R8");
        // R2: flag bits in instruction and descriptor have no effect
        run(MOV, 6'h09, 6'h21, 6'h00, 6'd5, 2'b11, 1'b0, "R2");
        expect_out(4'd9, vec(16'd5, 16'd6, 16'd7, 16'd8), "R2");
        // R10: unknown opcode writes nothing, no flag
        run(6'h3F, 6'h00, 6'h21, 6'h10, 6'd0, 2'b00, 1'b0, "R10");
        expect_out(4'd0, vec(16'd1, 16'd2, 16'd3, 16'd4), "R10");
        // R3 with R6: swizzled first source in a 3-lane product
        run(DP3, 6'h0A, 6'h20, 6'h21, 6'd2, 2'b00, 1'b0, "R6");
        expect_out(4'd10, vec(16'd36, 16'd36, 16'd36, 16'd36), "R6");
        // R3: second-source selector replicates x
        run(DP4, 6'h0B, 6'h20, 6'h21, 6'd6, 2'b00, 1'b0, "R3");
        expect_out(4'd11, vec(16'd50, 16'd50, 16'd50, 16'd50), "R3");
        // R11: no pulse while idle
        expect_idle("R11");

        repeat (3) @(negedge clk);
        finished = 1;
        summary();
    end

endmodule